// File: doc/BRIEF.md
# Word Shift-by-Immediate Execute Unit

This block decodes and executes the three 64-bit-machine word shifts whose shift distance is carried in the instruction itself: shift left logical, shift right logical and shift right arithmetic. It is purely combinational. It takes a 32-bit instruction word, a qualifying valid bit and the 64-bit value already read from the source register. In the same cycle it returns a hit flag, an illegal-encoding flag, the destination register index, a register write strobe and the 64-bit result.

Only the low 32 bits of the source take part in the shift. The 32-bit outcome is then widened to 64 bits by copying its bit 31, for all three operations, including the logical right shift. A surrounding pipeline reads the source register named in bits [19:15] and supplies its value. It then commits `result_o` to the register named by `rd_o` when `wen_o` is high.

The block has no states, so it has no state transitions. The operation choice is a decoded enumeration with four values: none, left-logical, right-logical and right-arithmetic.

Top module: `wsh_unit`

## Requirements
- R1: `match_o` is 1 exactly when `valid_i` is 1, instruction bits [6:0] equal 0011011, and the {bits[31:25], bits[14:12]} pair is one of 0000000/001, 0000000/101 or 0100000/101.
- R2: With funct7 0000000 and funct3 001, the result is the low source word shifted left by the amount in bits [24:20] (0 to 31), zero-filled, then sign-extended from bit 31 to 64 bits.
- R3: With funct7 0000000 and funct3 101, the result is the low source word shifted right with zero fill, then sign-extended from bit 31 of that shifted word.
- R4: With funct7 0100000 and funct3 101, the result is the low source word shifted right with vacated bits filled from source bit 31 (never bit 63), then sign-extended.
- R5: `rd_o` always equals instruction bits [11:7].
- R6: Source bits [63:32] have no effect on any output.
- R7: When `valid_i` is 1 and the opcode is 0011011 but the funct pair matches none of the three patterns, `illegal_o` is 1 and `match_o` and `wen_o` are 0.
- R8: `wen_o` is 1 exactly when `match_o` is 1 and `rd_o` is nonzero.
- R9: When `valid_i` is 0, `match_o`, `illegal_o` and `wen_o` are 0.
- R10: When `match_o` is 0, `result_o` is zero. An opcode other than 0011011 gives `illegal_o` = 0.
- R11: A shift amount of zero returns the low source word unchanged, sign-extended to 64 bits, for every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Qualifies the instruction and operand |
| instr_i | input | 32 | Instruction word |
| src_i | input | 64 | Value of the source register |
| match_o | output | 1 | One of the three word shifts was decoded |
| illegal_o | output | 1 | Right opcode with an unknown funct pair |
| rd_o | output | 5 | Destination register index |
| wen_o | output | 1 | Register write strobe, low for index 0 |
| result_o | output | 64 | Sign-extended shift result |

## Verification
Random source values with bit 31 set and bit 31 clear are shifted by random amounts. This shows whether each right shift fills from the correct bit, and whether the widening copies bit 31 instead of zero-extending. Random upper source halves, together with pairs of operands that share a low word but differ in the upper word, show whether bits [63:32] leak into the result. The funct fields are drawn partly from the three legal patterns and partly at random, and the opcode is sometimes wrong. This separates a hit from an illegal encoding and from a foreign instruction. Directed cases cover a shift amount of 0 or 31, a destination index of 0, and the valid bit held low.

// File: rtl/wsh_pkg.sv
package wsh_pkg;
    localparam int ILEN = 32;
    localparam int REGW = 5;

    localparam logic [6:0] OPC_WORD_IMM = 7'b0011011;
    localparam logic [6:0] F7_PLAIN     = 7'b0000000;
    localparam logic [6:0] F7_ARITH     = 7'b0100000;
    localparam logic [2:0] F3_LEFT      = 3'b001;
    localparam logic [2:0] F3_RIGHT     = 3'b101;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SLL  = 2'd1,
        OP_SRL  = 2'd2,
        OP_SRA  = 2'd3
    } wop_e;
endpackage

// File: rtl/wsh_decode.sv
module wsh_decode
    import wsh_pkg::*;
(
    input  logic            valid_i,
    input  logic [ILEN-1:0] instr_i,
    output wop_e            op_o,
    output logic            illegal_o
);
    logic [9:0] funct_pair;
    assign funct_pair = {instr_i[31:25], instr_i[14:12]};

    always_comb begin
        op_o      = OP_NONE;
        illegal_o = 1'b0;
        if (valid_i && instr_i[6:0] == OPC_WORD_IMM) begin
            unique case (funct_pair)
                {F7_PLAIN, F3_LEFT}:  op_o = OP_SLL;
                {F7_PLAIN, F3_RIGHT}: op_o = OP_SRL;
                {F7_ARITH, F3_RIGHT}: op_o = OP_SRA;
                default:              illegal_o = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/wsh_shifter.sv
module wsh_shifter
    import wsh_pkg::*;
#(
    parameter int WORD = 32,
    localparam int SHW = $clog2(WORD)
) (
    input  logic [WORD-1:0] word_i,
    input  logic [SHW-1:0]  shamt_i,
    input  wop_e            op_i,
    output logic [WORD-1:0] res_o
);
    logic [WORD-1:0] left_stg  [SHW+1];
    logic [WORD-1:0] right_stg [SHW+1];
    logic            fill;

    assign fill         = (op_i == OP_SRA) ? word_i[WORD-1] : 1'b0;
    assign left_stg[0]  = word_i;
    assign right_stg[0] = word_i;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int D = 1 << k;
        assign left_stg[k+1]  = shamt_i[k] ? {left_stg[k][WORD-1-D:0], {D{1'b0}}}
                                           : left_stg[k];
        assign right_stg[k+1] = shamt_i[k] ? {{D{fill}}, right_stg[k][WORD-1:D]}
                                           : right_stg[k];
    end

    always_comb begin
        unique case (op_i)
            OP_SLL:         res_o = left_stg[SHW];
            OP_SRL, OP_SRA: res_o = right_stg[SHW];
            default:        res_o = '0;
        endcase
    end
endmodule

// File: rtl/wsh_sext.sv
module wsh_sext #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 64
) (
    input  logic [IN_W-1:0]  in_i,
    output logic [OUT_W-1:0] out_o
);
    assign out_o = {{(OUT_W-IN_W){in_i[IN_W-1]}}, in_i};
endmodule

// File: rtl/wsh_unit.sv
module wsh_unit
    import wsh_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WORD = 32,
    localparam int SHW = $clog2(WORD)
) (
    input  logic            valid_i,
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] src_i,
    output logic            match_o,
    output logic            illegal_o,
    output logic [4:0]      rd_o,
    output logic            wen_o,
    output logic [XLEN-1:0] result_o
);
    wop_e            op;
    logic [WORD-1:0] shifted;
    logic [XLEN-1:0] widened;

    wsh_decode u_dec (
        .valid_i   (valid_i),
        .instr_i   (instr_i),
        .op_o      (op),
        .illegal_o (illegal_o)
    );

    wsh_shifter #(.WORD(WORD)) u_shf (
        .word_i  (src_i[WORD-1:0]),
        .shamt_i (instr_i[20 +: SHW]),
        .op_i    (op),
        .res_o   (shifted)
    );

    wsh_sext #(.IN_W(WORD), .OUT_W(XLEN)) u_ext (
        .in_i  (shifted),
        .out_o (widened)
    );

    assign rd_o     = instr_i[11:7];
    assign match_o  = (op != OP_NONE);
    assign wen_o    = match_o && (rd_o != '0);
    assign result_o = match_o ? widened : '0;
endmodule

// File: rtl/wsh_unit_chk.sv
module wsh_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            valid_i,
    input logic [31:0]     instr_i,
    input logic            match_o,
    input logic            illegal_o,
    input logic [4:0]      rd_o,
    input logic            wen_o,
    input logic [XLEN-1:0] result_o
);
    always_comb begin
        a_r9_idle_quiet: assert (valid_i || (!match_o && !illegal_o && !wen_o))
            else $error("R9 outputs active while valid low");
        a_r1_opcode_gate: assert (!match_o || instr_i[6:0] == 7'b0011011)
            else $error("R1 match with foreign opcode");
        a_r7_exclusive: assert (!(match_o && illegal_o))
            else $error("R7 match and illegal together");
        a_r8_no_x0_write: assert (!wen_o || (match_o && rd_o != 5'd0))
            else $error("R8 write strobe without hit or to x0");
        a_r5_rd_field: assert (rd_o == instr_i[11:7])
            else $error("R5 destination index mismatch");
        a_r10_zero_miss: assert (match_o || result_o == '0)
            else $error("R10 nonzero result without hit");
        a_r2_sign_wide: assert (result_o[XLEN-1:31] == '0 || (&result_o[XLEN-1:31]))
            else $error("R2 upper half is not a sign copy");
    end
endmodule

bind wsh_unit wsh_unit_chk #(.XLEN(XLEN)) u_chk (
    .valid_i   (valid_i),
    .instr_i   (instr_i),
    .match_o   (match_o),
    .illegal_o (illegal_o),
    .rd_o      (rd_o),
    .wen_o     (wen_o),
    .result_o  (result_o)
);

// File: tb/sim_wsh_unit.sv
`timescale 1ns/1ps
module sim_wsh_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i;
    logic [31:0] instr_i;
    logic [63:0] src_i;
    logic        match_o, illegal_o, wen_o;
    logic [4:0]  rd_o;
    logic [63:0] result_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wsh_unit u0 (
        .valid_i   (valid_i),
        .instr_i   (instr_i),
        .src_i     (src_i),
        .match_o   (match_o),
        .illegal_o (illegal_o),
        .rd_o      (rd_o),
        .wen_o     (wen_o),
        .result_o  (result_o)
    );

    function automatic logic [63:0] sx(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    // 0 none, 1 left, 2 right logical, 3 right arithmetic
    function automatic int exp_op(input logic v, input logic [31:0] ins);
        if (!v || ins[6:0] != 7'b0011011) return 0;
        if (ins[31:25] == 7'h00 && ins[14:12] == 3'b001) return 1;
        if (ins[31:25] == 7'h00 && ins[14:12] == 3'b101) return 2;
        if (ins[31:25] == 7'h20 && ins[14:12] == 3'b101) return 3;
        return 0;
    endfunction

    function automatic logic [63:0] exp_res(input int op, input logic [31:0] ins,
                                            input logic [63:0] s);
        logic [31:0] lo;
        int sh;
        lo = s[31:0];
        sh = int'(ins[24:20]);
        case (op)
            1: return sx(lo << sh);
            2: return sx(lo >> sh);
            3: return sx($unsigned($signed(lo) >>> sh));
            default: return 64'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply_and_check(input logic v, input logic [31:0] ins,
                                   input logic [63:0] s, input string tag);
        int op;
        logic ill;
        @(negedge clk);
        valid_i = v; instr_i = ins; src_i = s;
        #5;
        op  = exp_op(v, ins);
        ill = v && ins[6:0] == 7'b0011011 && op == 0;
        chk({tag, " R1 match"}, 64'(match_o), 64'(op != 0));
        chk({tag, " R7 illegal"}, 64'(illegal_o), 64'(ill));
        chk({tag, " R8 wen"}, 64'(wen_o), 64'(op != 0 && ins[11:7] != 5'd0));
        chk({tag, " R5 rd"}, 64'(rd_o), 64'(ins[11:7]));
        chk({tag, " R2/R3/R4/R10 result"}, result_o, exp_res(op, ins, s));
    endtask

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] sh,
                                       input logic [4:0] rs, input logic [2:0] f3,
                                       input logic [4:0] rd);
        return {f7, sh, rs, f3, rd, 7'b0011011};
    endfunction

    initial begin
        valid_i = 0; instr_i = '0; src_i = '0;
        void'($urandom(32'h5eed_0042));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Reset/idle state: valid low (R9)
        apply_and_check(1'b0, mk(7'h00, 5'd3, 5'd1, 3'b001, 5'd4), 64'hFFFF_FFFF_8000_0001, "R9 idle");
        // Shift amount zero per op (R11)
        apply_and_check(1'b1, mk(7'h00, 5'd0, 5'd1, 3'b001, 5'd2), 64'h1234_5678_9ABC_DEF0, "R11 sll0");
        apply_and_check(1'b1, mk(7'h00, 5'd0, 5'd1, 3'b101, 5'd2), 64'h0000_0000_8000_0000, "R11 srl0");
        apply_and_check(1'b1, mk(7'h20, 5'd0, 5'd1, 3'b101, 5'd2), 64'hFFFF_FFFF_7FFF_FFFF, "R11 sra0");
        // Shift by 31 (R2, R3, R4)
        apply_and_check(1'b1, mk(7'h00, 5'd31, 5'd1, 3'b001, 5'd3), 64'h0000_0000_0000_0001, "R2 sll31");
        apply_and_check(1'b1, mk(7'h00, 5'd31, 5'd1, 3'b101, 5'd3), 64'h0000_0000_8000_0000, "R3 srl31");
        apply_and_check(1'b1, mk(7'h20, 5'd31, 5'd1, 3'b101, 5'd3), 64'h0000_0000_8000_0000, "R4 sra31");
        // Arithmetic fill from bit 31, not bit 63 (R4)
        apply_and_check(1'b1, mk(7'h20, 5'd4, 5'd1, 3'b101, 5'd3), 64'hFFFF_FFFF_7000_0000, "R4 fill31");
        // Destination x0 (R8)
        apply_and_check(1'b1, mk(7'h00, 5'd1, 5'd1, 3'b001, 5'd0), 64'h0000_0000_4000_0000, "R8 x0");
        // Illegal pairs and foreign opcode (R7, R10)
        apply_and_check(1'b1, mk(7'h20, 5'd1, 5'd1, 3'b001, 5'd5), 64'h1, "R7 bad");
        apply_and_check(1'b1, mk(7'h01, 5'd1, 5'd1, 3'b101, 5'd5), 64'h1, "R7 bad2");
        apply_and_check(1'b1, {25'h0A5_0293, 7'b0010011}, 64'h1, "R10 foreign");

        // Upper half ignored (R6): same low word, two upper halves
        for (int i = 0; i < 20; i++) begin
            logic [31:0] ins, lo;
            logic [63:0] r_a;
            logic [2:0]  f3;
            logic [6:0]  f7;
            lo = $urandom;
            f3 = (i % 3 == 0) ? 3'b001 : 3'b101;
            f7 = (i % 3 == 2) ? 7'h20 : 7'h00;
            ins = mk(f7, 5'($urandom), 5'($urandom), f3, 5'($urandom));
            apply_and_check(1'b1, ins, {32'h0000_0000, lo}, "R6 a");
            r_a = result_o;
            apply_and_check(1'b1, ins, {32'hFFFF_FFFF, lo}, "R6 b");
            chk("R6 upper-half independence", result_o, r_a);
        end

        // Constrained random mix (R1..R11)
        for (int i = 0; i < 400; i++) begin
            logic [6:0]  f7, opc;
            logic [2:0]  f3;
            logic [31:0] ins;
            int pick;
            pick = int'($urandom % 4);
            f7 = (pick == 0) ? 7'h20 : (pick == 3) ? 7'($urandom) : 7'h00;
            pick = int'($urandom % 4);
            f3 = (pick == 0) ? 3'b001 : (pick == 3) ? 3'($urandom) : 3'b101;
            opc = ($urandom % 8 == 0) ? 7'($urandom) : 7'b0011011;
            ins = {f7, 5'($urandom), 5'($urandom), f3, 5'($urandom), opc};
            apply_and_check(($urandom % 10) != 0, ins, {32'($urandom), 32'($urandom)}, "rand");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule